// File: doc/BRIEF.md
# SDRAM Power and Clock Control

This block sits inside an SDRAM memory controller and owns one software-writable control word. From that word it produces the enable for the SDRAM clock output, the clock-enable pin (CKE), a self-refresh entry request to the command path, the self-refresh acknowledge that software polls, a refresh-permit flag for the refresh timers, and the manual initialization command (NORMAL, MODE, PALL, NOP) with a one-cycle strobe to the command issuer.

The transaction engine reports whether it is idle. The command path reports whether a command is in flight and confirms completion of a self-refresh entry command. Self-refresh is entered and left by software through one bit. The acknowledge tells software which mode the memory is really in. Clock gating is automatic when the clock-control bit is cleared. Deep-sleep power-down needs three bits set together.

Control word layout (bit positions): 0 = clock-control (1 = clock output runs continuously), 1 = clock-enable qualifier, 2 = memory-clock disable, 3 = self-refresh request, 5:4 = initialization command, 6 = deep-sleep. All higher bits are reserved. The reset value is 0x09.

Top module: `sdram_pwr_ctl`

## Requirements
- R1: After reset, rdata reads 0x09, sr_ack is 1, cke is 0, clk_out_en is 1, ref_en is 0, sr_cmd is 0, init_go is 0 and init_cmd is 0. The controller therefore starts in self-refresh.
- R2: A write stores bits 6:0 of wdata into the control word. Bits DW-1:7 always read 0, and writing ones to them has no effect.
- R3: With bit 0 (clock-control) at 1 and no deep sleep, clk_out_en stays 1 whether the bus is idle or not, including during self-refresh.
- R4: With bit 0 at 0, clk_out_en drops to 0 one cycle after the controller goes idle (xact_idle high, no command pending) and is 0 throughout self-refresh. It returns to 1 one cycle after xact_idle falls, outside self-refresh.
- R5: Bit 2 (memory-clock disable) set to 1 forces clk_out_en to 0 only while no transaction or command is pending. While xact_idle is 0 the clock runs.
- R6: Setting bit 3 raises sr_cmd, which stays high until sr_done is seen. cke then goes low, and sr_ack rises only in a cycle after cke is already low. ref_en is 0 in self-refresh.
- R7: Clearing bit 3 in self-refresh drives cke high. sr_ack falls only after cke has been high for at least EXIT_CYC cycles, and ref_en then returns to 1.
- R8: Bits 5:4 encode 0 = NORMAL, 1 = MODE, 2 = PALL, 3 = NOP, and init_cmd mirrors them. Each change of the field gives exactly one one-cycle init_go pulse with init_cmd holding the new code. Rewriting the same code gives no pulse.
- R9: init_go is issued only in a cycle after cmd_busy was low. While cmd_busy stays high the pulse is held back.
- R10: While bits 5:4 are non-zero, self-refresh entry is not started and deep sleep is not entered, so cke stays high during initialization.
- R11: Deep sleep (cke 0, clk_out_en 0, ref_en 0) is entered only when bits 6, 1 and 0 are all 1. With any one of them clear, cke and ref_en are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | DW | Write data |
| rdata | output | DW | Control word read-back, reserved bits zero |
| xact_idle | input | 1 | Transaction engine has nothing pending |
| cmd_busy | input | 1 | Command issuer is executing a command |
| sr_done | input | 1 | Self-refresh entry command has been issued |
| clk_out_en | output | 1 | Enable for the SDRAM clock output |
| cke | output | 1 | SDRAM clock-enable pin |
| sr_cmd | output | 1 | Request to issue self-refresh entry |
| sr_ack | output | 1 | Self-refresh acknowledge status |
| ref_en | output | 1 | Refresh timers may issue auto-refresh |
| init_cmd | output | 2 | Initialization command code |
| init_go | output | 1 | One-cycle strobe to issue init_cmd |

## Verification
The bench builds the block with DW = 32 and EXIT_CYC = 5. The short exit window lets a full self-refresh exit be timed against the minimum-wait rule within a few cycles, and the full-width word exercises all 25 reserved bits. With this exit window the bench can also chain entry, exit, deep sleep and every initialization code in one short run. The sr_done and cmd_busy handshakes are driven by hand, so the held request and the held-back strobe can each be observed for several cycles.

// File: rtl/sdpc_pkg.sv
package sdpc_pkg;
  localparam int CTL_W = 7;

  typedef enum logic [1:0] {
    INIT_NORMAL = 2'd0,
    INIT_MODE   = 2'd1,
    INIT_PALL   = 2'd2,
    INIT_NOP    = 2'd3
  } init_code_e;

  typedef struct packed {
    logic       deep;
    logic [1:0] init;
    logic       sr_req;
    logic       mclk_off;
    logic       cken;
    logic       ckctl;
  } ctl_t;

  localparam ctl_t CTL_RST = '{deep: 1'b0, init: INIT_NORMAL, sr_req: 1'b1,
                               mclk_off: 1'b0, cken: 1'b0, ckctl: 1'b1};

  typedef enum logic [1:0] {
    SR_NORM,
    SR_ENTER,
    SR_SELF,
    SR_EXIT
  } sr_state_e;
endpackage

// File: rtl/sdpc_ctrl_reg.sv
module sdpc_ctrl_reg
  import sdpc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctl_t          ctl,
  output logic [DW-1:0] rdata
);
  localparam int PAD_W = DW - CTL_W;

  logic unused_hi;
  assign unused_hi = ^wdata[DW-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) ctl <= CTL_RST;
    else if (wr_en) ctl <= ctl_t'(wdata[CTL_W-1:0]);
  end

  assign rdata = {{PAD_W{1'b0}}, ctl};
endmodule

// File: rtl/sdpc_sr_fsm.sv
module sdpc_sr_fsm
  import sdpc_pkg::*;
#(
  parameter int EXIT_CYC = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sr_req,
  input  logic      init_busy,
  input  logic      sr_done,
  output sr_state_e state,
  output logic      sr_cmd
);
  localparam int CW = $clog2(EXIT_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SR_SELF;
      cnt   <= '0;
    end else begin
      case (state)
        SR_NORM:  if (sr_req && !init_busy) state <= SR_ENTER;
        SR_ENTER: if (sr_done) state <= SR_SELF;
        SR_SELF: begin
          if (!sr_req) begin
            state <= SR_EXIT;
            cnt   <= CW'(EXIT_CYC);
          end
        end
        SR_EXIT: begin
          if (cnt == '0) state <= SR_NORM;
          else cnt <= cnt - 1'b1;
        end
        default: state <= SR_SELF;
      endcase
    end
  end

  assign sr_cmd = (state == SR_ENTER);
endmodule

// File: rtl/sdpc_init_seq.sv
module sdpc_init_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] field,
  input  logic       cmd_busy,
  output logic [1:0] init_cmd,
  output logic       init_go,
  output logic       pend
);
  logic [1:0] prev_q;
  logic       go_d;

  assign go_d = pend && !cmd_busy && !init_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 2'd0;
      pend     <= 1'b0;
      init_go  <= 1'b0;
      init_cmd <= 2'd0;
    end else begin
      prev_q   <= field;
      init_cmd <= field;
      init_go  <= go_d;
      if (field != prev_q) pend <= 1'b1;
      else if (go_d) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_pwr_ctl.sv
module sdram_pwr_ctl
  import sdpc_pkg::*;
#(
  parameter int DW       = 32,
  parameter int EXIT_CYC = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          xact_idle,
  input  logic          cmd_busy,
  input  logic          sr_done,
  output logic          clk_out_en,
  output logic          cke,
  output logic          sr_cmd,
  output logic          sr_ack,
  output logic          ref_en,
  output logic [1:0]    init_cmd,
  output logic          init_go
);
  ctl_t      ctl;
  sr_state_e state;
  logic      init_busy;
  logic      pend;
  logic      deep_act;
  logic      active;
  logic      in_self;

  sdpc_ctrl_reg #(.DW(DW)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata),
    .ctl(ctl), .rdata(rdata)
  );

  assign init_busy = (ctl.init != INIT_NORMAL);

  sdpc_sr_fsm #(.EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk(clk), .rst(rst), .sr_req(ctl.sr_req), .init_busy(init_busy),
    .sr_done(sr_done), .state(state), .sr_cmd(sr_cmd)
  );

  sdpc_init_seq u_init (
    .clk(clk), .rst(rst), .field(ctl.init), .cmd_busy(cmd_busy),
    .init_cmd(init_cmd), .init_go(init_go), .pend(pend)
  );

  assign in_self  = (state == SR_SELF);
  assign deep_act = ctl.deep && ctl.cken && ctl.ckctl && !init_busy;
  assign active   = !xact_idle || sr_cmd || pend || init_go || (state == SR_EXIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke        <= 1'b0;
      sr_ack     <= 1'b1;
      ref_en     <= 1'b0;
      clk_out_en <= 1'b1;
    end else begin
      cke        <= !(in_self || deep_act);
      sr_ack     <= (in_self && !cke) || (state == SR_EXIT);
      ref_en     <= ((state == SR_NORM) || (state == SR_ENTER)) && !deep_act;
      clk_out_en <= !deep_act && !(ctl.mclk_off && !active) &&
                    (ctl.ckctl || (active && !in_self));
    end
  end
endmodule

// File: rtl/sdpc_checker.sv
module sdpc_checker #(
  parameter int DW       = 32,
  parameter int EXIT_CYC = 16
) (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic sr_ack,
  input logic sr_cmd,
  input logic sr_done,
  input logic init_go,
  input logic cmd_busy
);
  localparam int HW = $clog2(EXIT_CYC + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !cke) hi_cnt <= '0;
    else if (hi_cnt != HW'(EXIT_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  p_ack_after_cke_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_ack) |-> (!cke && !$past(cke)));

  p_req_held_r6: assert property (@(posedge clk) disable iff (rst)
    (sr_cmd && !sr_done) |=> sr_cmd);

  p_exit_wait_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_ack) |-> (cke && (hi_cnt >= HW'(EXIT_CYC))));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    init_go |=> !init_go);

  p_wait_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    init_go |-> !$past(cmd_busy));
endmodule

bind sdram_pwr_ctl sdpc_checker #(.DW(DW), .EXIT_CYC(EXIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .sr_ack(sr_ack), .sr_cmd(sr_cmd),
  .sr_done(sr_done), .init_go(init_go), .cmd_busy(cmd_busy)
);

// File: tb/sdram_pwr_ctl_test.sv
`timescale 1ns/1ps
module sdram_pwr_ctl_test;
  localparam int DW = 32;
  localparam int EXIT_CYC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic xact_idle = 1'b1;
  logic cmd_busy = 1'b0;
  logic sr_done = 1'b0;
  logic clk_out_en, cke, sr_cmd, sr_ack, ref_en, init_go;
  logic [1:0] init_cmd;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_pwr_ctl #(.DW(DW), .EXIT_CYC(EXIT_CYC)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .xact_idle(xact_idle), .cmd_busy(cmd_busy), .sr_done(sr_done),
    .clk_out_en(clk_out_en), .cke(cke), .sr_cmd(sr_cmd), .sr_ack(sr_ack),
    .ref_en(ref_en), .init_cmd(init_cmd), .init_go(init_go)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [DW-1:0] v);
    wr_en = 1'b1;
    wdata = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic count_go(int n, output int pulses, output logic [1:0] code);
    pulses = 0;
    code = 2'd0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (init_go) begin
        pulses++;
        code = init_cmd;
      end
    end
  endtask

  task automatic wait_ack_low();
    for (int i = 0; i < 200; i++) begin
      if (!sr_ack) break;
      tick();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick();
    chk("R1 rdata", rdata, 32'h09);
    chk("R1 sr_ack", sr_ack, 1);
    chk("R1 cke", cke, 0);
    chk("R1 clk_out_en", clk_out_en, 1);
    chk("R1 ref_en", ref_en, 0);
    chk("R1 sr_cmd", sr_cmd, 0);
    chk("R1 init_go", init_go, 0);
    chk("R1 init_cmd", init_cmd, 0);
  endtask

  task automatic t_reserved();
    wr(32'hFFFF_FF89);
    chk("R2 reserved read zero", rdata, 32'h09);
    tick(2);
    chk("R2 state unchanged ack", sr_ack, 1);
    chk("R3 clock runs in self-refresh", clk_out_en, 1);
  endtask

  task automatic t_exit();
    int t_cke = -1;
    int t_ack = -1;
    wr(32'h01);
    for (int i = 0; i < 100; i++) begin
      tick();
      if (cke && t_cke < 0) t_cke = i;
      if (!sr_ack && t_ack < 0) begin
        t_ack = i;
        break;
      end
    end
    chk("R7 cke rose", (t_cke >= 0), 1);
    chk("R7 ack fell", (t_ack >= 0), 1);
    chk("R7 exit wait long enough", ((t_ack - t_cke) >= EXIT_CYC), 1);
    chk("R7 ref_en back", ref_en, 1);
  endtask

  task automatic t_ckctl();
    wr(32'h00);
    tick(2);
    chk("R4 gated when idle", clk_out_en, 0);
    xact_idle = 1'b0;
    tick();
    chk("R4 runs when busy", clk_out_en, 1);
    xact_idle = 1'b1;
    tick(2);
    chk("R4 gated again", clk_out_en, 0);
    wr(32'h01);
    tick();
    chk("R3 continuous when idle", clk_out_en, 1);
  endtask

  task automatic t_mclk_off();
    wr(32'h05);
    tick(2);
    chk("R5 disabled when idle", clk_out_en, 0);
    xact_idle = 1'b0;
    tick();
    chk("R5 honoured only when idle", clk_out_en, 1);
    xact_idle = 1'b1;
    tick(2);
    chk("R5 disabled again", clk_out_en, 0);
    wr(32'h01);
    tick();
    chk("R5 restored", clk_out_en, 1);
  endtask

  task automatic t_init();
    int p;
    logic [1:0] c;
    cmd_busy = 1'b1;
    wr(32'h21);
    count_go(6, p, c);
    chk("R9 held while busy", p, 0);
    chk("R8 PALL code mirrored", init_cmd, 2);
    chk("R10 cke high in init", cke, 1);
    cmd_busy = 1'b0;
    count_go(6, p, c);
    chk("R9 one pulse after busy", p, 1);
    chk("R8 PALL code at pulse", c, 2);
    wr(32'h31);
    count_go(6, p, c);
    chk("R8 NOP one pulse", p, 1);
    chk("R8 NOP code", c, 3);
    wr(32'h31);
    count_go(6, p, c);
    chk("R8 same code no pulse", p, 0);
    wr(32'h11);
    count_go(6, p, c);
    chk("R8 MODE one pulse", p, 1);
    chk("R8 MODE code", c, 1);
    wr(32'h01);
    count_go(6, p, c);
    chk("R8 NORMAL one pulse", p, 1);
    chk("R8 NORMAL code", c, 0);
  endtask

  task automatic t_entry();
    wr(32'h29);
    tick(8);
    chk("R10 no entry during init", sr_cmd, 0);
    chk("R10 cke held", cke, 1);
    chk("R10 no ack", sr_ack, 0);
    wr(32'h08);
    tick(2);
    chk("R6 request raised", sr_cmd, 1);
    tick(4);
    chk("R6 request held", sr_cmd, 1);
    chk("R6 cke high before done", cke, 1);
    sr_done = 1'b1;
    tick();
    sr_done = 1'b0;
    tick();
    chk("R6 cke low", cke, 0);
    chk("R6 ack not before cke low", sr_ack, 0);
    chk("R6 request dropped", sr_cmd, 0);
    tick();
    chk("R6 ack raised", sr_ack, 1);
    chk("R4 gated in self-refresh", clk_out_en, 0);
    chk("R6 refresh stopped", ref_en, 0);
    wr(32'h00);
    wait_ack_low();
    chk("R7 left self-refresh", sr_ack, 0);
    chk("R7 cke high after exit", cke, 1);
    wr(32'h01);
    tick();
  endtask

  task automatic t_deep();
    wr(32'h42);
    tick(2);
    chk("R11 two bits no deep cke", cke, 1);
    chk("R11 two bits no deep ref", ref_en, 1);
    wr(32'h41);
    tick(2);
    chk("R11 no cken no deep", cke, 1);
    wr(32'h43);
    tick(2);
    chk("R11 deep cke low", cke, 0);
    chk("R11 deep clock off", clk_out_en, 0);
    chk("R11 deep refresh off", ref_en, 0);
    wr(32'h63);
    tick(2);
    chk("R10 init blocks deep", cke, 1);
    wr(32'h01);
    tick(3);
    chk("R11 recovered cke", cke, 1);
    chk("R11 recovered clock", clk_out_en, 1);
  endtask

  initial begin
    t_reset();
    t_reserved();
    t_exit();
    t_ckctl();
    t_mclk_off();
    t_init();
    t_entry();
    t_deep();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule